// File: doc/BRIEF.md
# Modulo Up-Counter Timer

This block is a register-mapped 16-bit timer that counts up from a programmable start value to a programmable limit, then reloads the start value and raises an overflow flag. A power-of-two prescaler sets the count rate. A two-bit clock-source field in the control register selects between stopped and running from the main clock. An interrupt output follows the overflow flag when the interrupt enable is set.

Software reaches the timer through a simple 32-bit register port. Writes complete in one cycle and reads are combinational. A configuration pin reverses the byte order of every access, so the block can sit on either a big-endian or a little-endian bus.

Writes to the limit and start-value registers go into holding buffers. The live copies take those values only while the clock source is set to stopped, so a period can never change in the middle of a count. Any write to the counter register reloads the counter from the live start value, whatever data is written.

Top module: `modulo_timer`

## Requirements
- R1: After reset every register reads zero (counter, control, limit and start value) and `irq` is low.
- R2: The counter advances by one on each prescaled tick while the clock-source field (control bits [4:3]) equals 1. It holds its value for the values 0, 2 and 3.
- R3: On a tick where the counter equals the live limit, the counter loads the live start value and the overflow flag (control bit 7) sets. With start 0, a period of N ticks needs limit N-1.
- R4: A tick occurs every 2^P main-clock cycles, where P is the prescale field (control bits [2:0]). While the clock source is 0 the prescaler count is held at zero, so the first tick after starting comes exactly 2^P cycles after the starting write.
- R5: A write of any data to the counter register (offset 0x04) loads the counter with the live start value. The written data is ignored.
- R6: Writes to the limit (offset 0x08) and start-value (offset 0x4C) registers land in a holding buffer. The live copy takes the buffer value only on clock edges where the clock-source field is 0. Reads return the live copy.
- R7: A control write with bit 7 at 0 clears the overflow flag. A write with bit 7 at 1 leaves the flag unchanged.
- R8: If a flag-clearing control write falls in the same cycle as a new overflow, the flag stays set.
- R9: `irq` is high exactly when both the overflow flag and the interrupt enable (control bit 6) are 1.
- R10: When `big_endian` is 1, write data and read data are byte-reversed at the port, so a value placed in the top byte of the bus reaches register bit [7:0].
- R11: The control register reads back prescale in [2:0], clock source in [4:3], enable in [6] and flag in [7]. Control bit 5, bits above each field, and addresses other than 0x00, 0x04, 0x08 and 0x4C read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; also the count clock source |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian | input | 1 | 1 reverses byte order of bus data |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Overflow interrupt request |

## Verification
The overflow flag has two writers that can act on the same edge: the counter wrapping from the limit back to the start value, and a software control write that clears the flag. The bench sets a short period, starts the counter with a single-cycle write, and counts edges so that a clearing write lands on the exact edge where the counter wraps. The flag and `irq` must read high afterwards. One tick later, a second clearing write with no overflow must take effect, which confirms the first result came from the overflow winning and not from a write that was ignored.

// File: rtl/wt_pkg.sv
// Package: shared constants and types of the modulo timer.
// Assumes a 32-bit register port with 8-bit byte offsets.
package wt_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned ADDR_W = 8;

    // Register offsets
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_LIM  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_INIT = 8'h4C;

    // Control register field positions
    localparam int unsigned CTRL_PS_LSB   = 0;
    localparam int unsigned CTRL_SRC_LSB  = 3;
    localparam int unsigned CTRL_SRC_W    = 2;
    localparam int unsigned CTRL_IE_BIT   = 6;
    localparam int unsigned CTRL_FLAG_BIT = 7;

    // Clock-source selection
    typedef enum logic [CTRL_SRC_W-1:0] {
        SRC_OFF  = 2'd0,
        SRC_MAIN = 2'd1,
        SRC_RSV2 = 2'd2,
        SRC_RSV3 = 2'd3
    } src_e;
endpackage

// File: rtl/wt_prescale.sv
// Module: power-of-two prescaler. Emits a one-cycle tick every 2^ps
// cycles while run is high; the count is forced to zero while stopped.
// Assumes ps changes only through the control register.
module wt_prescale #(
    parameter int unsigned PS_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int unsigned DIV_W = (1 << PS_W) - 1;

    logic [DIV_W-1:0] pcnt;
    logic [DIV_W-1:0] mask;

    // Terminal count: low ps bits set
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(ps));
        end
    end

    assign tick = run && (pcnt == mask);

    // Divider count, cleared on tick and while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pcnt <= '0;
        end else if (tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    // R4: a stopped prescaler restarts from zero
    a_r4_zero_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pcnt == '0));
endmodule

// File: rtl/wt_count.sv
// Module: modulo up-counter. Advances on tick, reloads the start value
// after the limit, and loads the start value on a software write.
// Assumes load and tick come from independent sources.
module wt_count #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] init_val,
    input  logic [CNT_W-1:0] lim_val,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    logic at_lim;

    assign at_lim = (cnt == lim_val);
    assign ovf    = tick && !load && at_lim;

    // Counter state: software load beats a tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= init_val;
        end else if (tick) begin
            cnt <= at_lim ? init_val : cnt + 1'b1;
        end
    end

    // R5: software write loads the start value
    a_r5_write_loads_init: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt == $past(init_val)));
    // R3: overflow reloads the start value
    a_r3_wrap_to_init: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (cnt == $past(init_val)));
    // R2: an ordinary tick adds one
    a_r2_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !ovf) |=> (cnt == $past(cnt) + 1'b1));
    // R2: no tick, no change
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> $stable(cnt));
endmodule

// File: rtl/wt_regs.sv
// Module: register decode for the modulo timer. Holds control fields,
// overflow flag and the buffered limit/start registers.
// Assumes bus data is already in native byte order.
module wt_regs
    import wt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              ovf,
    output src_e              src,
    output logic [PS_W-1:0]   ps,
    output logic              ie,
    output logic              flag,
    output logic [CNT_W-1:0]  init_act,
    output logic [CNT_W-1:0]  lim_act,
    output logic              cnt_load,
    output logic [BUS_W-1:0]  rdata
);
    logic             wr_ctrl, wr_cnt, wr_lim, wr_init;
    logic [CNT_W-1:0] init_buf, lim_buf;
    logic             unused_hi;

    assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
    assign wr_cnt   = wr_en && (addr == OFS_CNT);
    assign wr_lim   = wr_en && (addr == OFS_LIM);
    assign wr_init  = wr_en && (addr == OFS_INIT);
    assign cnt_load = wr_cnt;
    assign unused_hi = ^wdata[BUS_W-1:CNT_W];

    // Control fields written as a whole
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps  <= '0;
            src <= SRC_OFF;
            ie  <= 1'b0;
        end else if (wr_ctrl) begin
            ps  <= wdata[CTRL_PS_LSB +: PS_W];
            src <= src_e'(wdata[CTRL_SRC_LSB +: CTRL_SRC_W]);
            ie  <= wdata[CTRL_IE_BIT];
        end
    end

    // Overflow flag: set by hardware, cleared by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (ovf) begin
            flag <= 1'b1;
        end else if (wr_ctrl && !wdata[CTRL_FLAG_BIT]) begin
            flag <= 1'b0;
        end
    end

    // Holding buffers take every bus write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_buf  <= '0;
            init_buf <= '0;
        end else begin
            if (wr_lim)  lim_buf  <= wdata[CNT_W-1:0];
            if (wr_init) init_buf <= wdata[CNT_W-1:0];
        end
    end

    // Live copies follow the buffers only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_act  <= '0;
            init_act <= '0;
        end else if (src == SRC_OFF) begin
            lim_act  <= lim_buf;
            init_act <= init_buf;
        end
    end

    // Read multiplexer; unused bits and offsets give zero
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_CTRL: begin
                rdata[CTRL_PS_LSB +: PS_W]        = ps;
                rdata[CTRL_SRC_LSB +: CTRL_SRC_W] = src;
                rdata[CTRL_IE_BIT]                = ie;
                rdata[CTRL_FLAG_BIT]              = flag;
            end
            OFS_CNT:  rdata[CNT_W-1:0] = cnt;
            OFS_LIM:  rdata[CNT_W-1:0] = lim_act;
            OFS_INIT: rdata[CNT_W-1:0] = init_act;
            default:  rdata = '0;
        endcase
    end

    // R8: a new overflow always leaves the flag set
    a_r8_overflow_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);
    // R7: writing one to a clear flag does not set it
    a_r7_one_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[CTRL_FLAG_BIT] && !flag && !ovf) |=> !flag);
    // R6: live limit frozen while a clock is selected
    a_r6_lim_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_OFF) |=> $stable(lim_act));
    // R6: live start value frozen while a clock is selected
    a_r6_init_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (src != SRC_OFF) |=> $stable(init_act));
endmodule

// File: rtl/modulo_timer.sv
// Module: top of the modulo timer. Byte-order steering at the port,
// register block, prescaler and counter. Assumes PS_W <= 3 so the
// prescale field fits below the clock-source field.
module modulo_timer
    import wt_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned PS_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              big_endian,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    localparam int unsigned LANES = BUS_W / 8;

    logic [BUS_W-1:0] wdata_n, rdata_n;
    src_e             src;
    logic [PS_W-1:0]  ps;
    logic             ie, flag, tick, ovf, cnt_load, run;
    logic [CNT_W-1:0] cnt, init_act, lim_act;

    // Byte lane steering for both directions
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign wdata_n[8*b +: 8]   = big_endian ? bus_wdata[8*(LANES-1-b) +: 8] : bus_wdata[8*b +: 8];
        assign bus_rdata[8*b +: 8] = big_endian ? rdata_n[8*(LANES-1-b) +: 8]   : rdata_n[8*b +: 8];
    end

    assign run = (src == SRC_MAIN);
    assign irq = flag && ie;

    wt_regs #(.CNT_W(CNT_W), .PS_W(PS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(wdata_n), .cnt(cnt), .ovf(ovf), .src(src), .ps(ps),
        .ie(ie), .flag(flag), .init_act(init_act), .lim_act(lim_act),
        .cnt_load(cnt_load), .rdata(rdata_n)
    );

    wt_prescale #(.PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .ps(ps), .tick(tick)
    );

    wt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .load(cnt_load),
        .init_val(init_act), .lim_val(lim_act), .cnt(cnt), .ovf(ovf)
    );

    // R9: interrupt drops whenever the flag is clear
    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |-> !irq);
endmodule

// File: tb/sim_modulo_timer.sv
`timescale 1ns/1ps
module sim_modulo_timer;
    localparam logic [7:0] A_CTRL = 8'h00, A_CNT = 8'h04, A_LIM = 8'h08, A_INIT = 8'h4C;

    // {ps[3], init[16], limit[16], edges[16], exp_cnt[16], exp_flag[1]}
    localparam logic [67:0] VEC [0:6] = '{
        {3'd0, 16'd0,      16'd9,      16'd5,  16'd5,      1'b0},
        {3'd0, 16'd0,      16'd9,      16'd10, 16'd0,      1'b1},
        {3'd0, 16'd100,    16'd103,    16'd6,  16'd102,    1'b1},
        {3'd2, 16'd0,      16'hFFFF,   16'd20, 16'd5,      1'b0},
        {3'd3, 16'd5,      16'd6,      16'd24, 16'd6,      1'b1},
        {3'd1, 16'hFFFE,   16'hFFFF,   16'd4,  16'hFFFE,   1'b1},
        {3'd0, 16'd7,      16'd7,      16'd3,  16'd7,      1'b1}
    };

    logic        clk = 1'b0, rst_n = 1'b0, big_endian = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    modulo_timer u0 (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One write, one edge; starts and ends at a falling edge
    task automatic wr1(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Write followed by one idle edge so live copies settle
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr1(a, d);
        @(posedge clk); @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_wr = 1'b0;
        #1 d = bus_rdata;
    endtask

    task automatic stop_all();
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, d2;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, d); check("R1 ctrl", d, 32'h0);
        rd(A_CNT, d);  check("R1 cnt", d, 32'h0);
        rd(A_LIM, d);  check("R1 limit", d, 32'h0);
        rd(A_INIT, d); check("R1 init", d, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // Table walk: R2 R3 R4 counting, wrap and prescale
        for (int i = 0; i < 7; i++) begin
            logic [67:0] v;
            v = VEC[i];
            stop_all();
            wr(A_LIM, {16'h0, v[48:33]});
            wr(A_INIT, {16'h0, v[64:49]});
            wr(A_CNT, 32'hDEAD_BEEF);
            wr1(A_CTRL, 32'h08 | {29'b0, v[67:65]});
            repeat (v[32:17]) @(posedge clk);
            @(negedge clk);
            rd(A_CNT, d);
            check($sformatf("R2 R3 R4 vec%0d count", i), d, {16'h0, v[16:1]});
            rd(A_CTRL, d);
            check($sformatf("R3 vec%0d flag", i), {31'b0, d[7]}, {31'b0, v[0]});
        end

        // R2: counter holds once stopped
        stop_all();
        rd(A_CNT, d);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rd(A_CNT, d2); check("R2 hold when stopped", d2, d);

        // R5: counter write loads start value, data ignored
        wr(A_INIT, 32'h33);
        wr(A_CNT, 32'hABCD);
        rd(A_CNT, d); check("R5 count write loads init", d, 32'h33);

        // R7: writing one to a clear flag has no effect
        stop_all();
        wr1(A_CTRL, 32'h80);
        rd(A_CTRL, d); check("R7 write one ignored", d, 32'h0);

        // R6: buffered writes wait for the stop
        stop_all();
        wr(A_LIM, 32'h5); wr(A_INIT, 32'h0); wr(A_CNT, 32'h0);
        wr1(A_CTRL, 32'h08);
        wr(A_LIM, 32'h20);
        wr(A_INIT, 32'h2);
        rd(A_LIM, d);  check("R6 limit held while running", d, 32'h5);
        rd(A_INIT, d); check("R6 init held while running", d, 32'h0);
        wr(A_CTRL, 32'h0);
        rd(A_LIM, d);  check("R6 limit transferred when stopped", d, 32'h20);
        rd(A_INIT, d); check("R6 init transferred when stopped", d, 32'h2);

        // R8: clear write on the overflow edge loses
        stop_all();
        wr(A_LIM, 32'h3); wr(A_INIT, 32'h0); wr(A_CNT, 32'h0);
        wr1(A_CTRL, 32'h48);
        repeat (3) @(posedge clk);
        @(negedge clk);
        wr1(A_CTRL, 32'h48);
        rd(A_CTRL, d); check("R8 overflow beats clear", d, 32'hC8);
        check("R9 irq with flag and enable", {31'b0, irq}, 32'h1);
        wr1(A_CTRL, 32'h48);
        rd(A_CTRL, d); check("R7 clear by writing zero", d, 32'h48);
        check("R9 irq low after clear", {31'b0, irq}, 32'h0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rd(A_CTRL, d); check("R3 flag on next wrap", d, 32'hC8);
        wr1(A_CTRL, 32'h88);
        rd(A_CTRL, d); check("R7 write one keeps flag", d, 32'h88);
        check("R9 irq gated by enable", {31'b0, irq}, 32'h0);

        // R10: byte order
        stop_all();
        big_endian = 1'b1;
        wr(A_LIM, 32'h3412_0000);
        rd(A_LIM, d); check("R10 big-endian readback", d, 32'h3412_0000);
        big_endian = 1'b0;
        rd(A_LIM, d); check("R10 native value", d, 32'h0000_1234);

        // R11: field layout and unused bits
        wr(A_CTRL, 32'hFFFF_FF75);
        rd(A_CTRL, d); check("R11 ctrl fields", d, 32'h55);
        rd(8'h10, d);  check("R11 unused offset", d, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule